// File: doc/BRIEF.md
# Block Carry-Skip Adder

This block adds two N-bit operands and a carry-in, and produces an N-bit sum and a carry-out. It has no clock. The operand bits are split into ripple groups. Each group ripples its carry bit by bit. Each group also forms one group-propagate flag, which is the AND of the propagate signals of its bits. When that flag is set, a multiplexer sends the group's carry-in straight to its carry-out and the ripple chain is not used. When the flag is clear, the group itself generates or kills the carry, and the rippled value is selected.

By default the adder is 16 bits wide with four equal groups of 4 bits. A mode parameter switches to a list of group sizes, which may differ from group to group and must add up to the width. A second optional skip level joins adjacent pairs of groups. When both first-level group flags of a pair are set, the carry into the pair passes over both groups at once. The block is meant for a datapath in which every output must equal plain binary addition, whatever the internal carry structure is.

Top module: `csa_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals opa + opb + carry_in taken as an unsigned (WIDTH+1)-bit value.
- R2: Each bit position forms generate = a&b, propagate = a^b and kill = ~a&~b. Inside a group the carry follows c(i+1) = g(i) | p(i)&c(i), and sum bit i = p(i) ^ c(i). A carry generated at bit 0 that then propagates through bits 1 to 15 gives sum 0 and carry_out 1.
- R3: When every bit propagates (opa == ~opb), carry_out equals carry_in and every sum bit equals ~carry_in. This is checked with carry_in 0 and with carry_in 1.
- R4: When all bits of a group propagate, the group's carry-out equals its carry-in, and this always agrees with the group's rippled carry.
- R5: A group that has no generating bit and at least one killing bit gives a carry-out of 0, whatever its carry-in.
- R6: In the default uniform mode (VAR_MODE = 0) the groups are bits 0-3, 4-7, 8-11 and 12-15. With VAR_MODE = 1 the group sizes come from VAR_SIZES, listed from the LSB upward, and their sum must equal WIDTH.
- R7: With SKIP2 = 1, the carry into the pair of groups 2k and 2k+1 bypasses both groups when both group flags are set. The result still satisfies R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the MSB |

## Verification
The block has no state, so any fault in a group-propagate flag, a bypass multiplexer or a ripple stage shows at the ports in the same evaluation as the input that exposes it. A wrong bypass usually appears only for operands that make a whole group propagate while a carry arrives from below. For that reason the stimulus includes vectors that propagate across the full width and across single groups, and vectors that kill inside a group. Exhaustive sweeps on a narrow instance, and random sweeps on the uniform, non-uniform and two-level variants, compare the ports with arithmetic addition.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } bit_gpk_t;

    function automatic bit_gpk_t bit_gpk(input logic x, input logic y);
        bit_gpk_t r;
        r.gen  = x & y;
        r.prop = x ^ y;
        r.kill = ~x & ~y;
        return r;
    endfunction

endpackage

// File: rtl/csa_gp_stage.sv
module csa_gp_stage
    import csa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] g,
    output logic [W-1:0] p,
    output logic [W-1:0] k
);

    for (genvar i = 0; i < W; i++) begin : gen_bit
        bit_gpk_t t;
        assign t    = bit_gpk(a[i], b[i]);
        assign g[i] = t.gen;
        assign p[i] = t.prop;
        assign k[i] = t.kill;
    end

    // R2: exactly one of generate, propagate or kill holds in each bit, checked against the operands
    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r2_gpk_partition: assert ((g | p | k) == {W{1'b1}} && (g & k) == '0 && (p ^ (a ^ b)) == '0)
                else $error("R2: generate/propagate/kill mismatch");
        end
    end

endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] g,
    input  logic [W-1:0] p,
    input  logic [W-1:0] k,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         bp
);

    typedef struct packed {
        logic [W-1:0] sum;
        logic         rip;
        logic         bp;
    } grp_calc_t;

    grp_calc_t calc_d;

    always_comb begin
        logic c;
        calc_d = '0;
        c = cin;
        for (int i = 0; i < W; i++) begin
            calc_d.sum[i] = p[i] ^ c;
            c = g[i] | (p[i] & c);
        end
        calc_d.rip = c;
        calc_d.bp  = &p;
    end

    assign sum  = calc_d.sum;
    assign bp   = calc_d.bp;
    assign cout = calc_d.bp ? cin : calc_d.rip;

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            // R4: the bypassed carry never disagrees with the rippled carry
            a_r4_skip_vs_ripple: assert (cout == calc_d.rip)
                else $error("R4: bypass carry differs from ripple carry");
            // R2: group result is the arithmetic sum of its slice
            a_r2_group_arith: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
                else $error("R2: group arithmetic mismatch");
            // R5: no generate and some kill means no carry leaves the group
            if (g == '0 && k != '0) begin
                a_r5_kill_blocks: assert (cout == 1'b0)
                    else $error("R5: killed group passed a carry");
            end
        end
    end

endmodule

// File: rtl/csa_skip2.sv
module csa_skip2 (
    input  logic bp_lo,
    input  logic bp_hi,
    input  logic c_pair_in,
    input  logic c_hi_out1,
    output logic c_pair_out
);

    assign c_pair_out = (bp_lo & bp_hi) ? c_pair_in : c_hi_out1;

    // R7: the pair bypass agrees with the first-level carry chain
    always_comb begin
        if (!$isunknown({bp_lo, bp_hi, c_pair_in, c_hi_out1})) begin
            a_r7_pair_agrees: assert (c_pair_out == c_hi_out1)
                else $error("R7: second-level skip disagrees with first level");
        end
    end

endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int WIDTH     = 16,
    parameter int GRP       = 4,
    parameter int VAR_MODE  = 0,
    parameter int NVAR      = 4,
    parameter int VAR_SIZES [NVAR] = '{3, 5, 5, 3},
    parameter int SKIP2     = 0
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NG = (VAR_MODE != 0) ? NVAR : WIDTH / GRP;

    function automatic int grp_size(input int n);
        if (VAR_MODE != 0) return VAR_SIZES[n];
        return GRP;
    endfunction

    function automatic int grp_lo(input int n);
        int s;
        s = 0;
        for (int j = 0; j < n; j++) s += grp_size(j);
        return s;
    endfunction

    logic [WIDTH-1:0] g_w, p_w, k_w;

    csa_gp_stage #(.W(WIDTH)) u_gp (
        .a(opa), .b(opb), .g(g_w), .p(p_w), .k(k_w)
    );

    for (genvar n = 0; n < NG; n++) begin : gen_grp
        localparam int LO = grp_lo(n);
        localparam int SZ = grp_size(n);
        logic c_in, c_out1, c_out, bpv;
        logic [SZ-1:0] s_w;

        if (n == 0) begin : gen_first
            assign c_in = carry_in;
        end else begin : gen_next
            assign c_in = gen_grp[n-1].c_out;
        end

        csa_group #(.W(SZ)) u_grp (
            .a(opa[LO +: SZ]), .b(opb[LO +: SZ]),
            .g(g_w[LO +: SZ]), .p(p_w[LO +: SZ]), .k(k_w[LO +: SZ]),
            .cin(c_in), .sum(s_w), .cout(c_out1), .bp(bpv)
        );

        assign sum[LO +: SZ] = s_w;

        if (SKIP2 != 0 && (n % 2) == 1) begin : gen_pair
            csa_skip2 u_skip2 (
                .bp_lo(gen_grp[n-1].bpv), .bp_hi(bpv),
                .c_pair_in(gen_grp[n-1].c_in), .c_hi_out1(c_out1),
                .c_pair_out(c_out)
            );
        end else begin : gen_single
            assign c_out = c_out1;
        end
    end

    assign carry_out = gen_grp[NG-1].c_out;

    // R6: group sizes must tile the full width
    initial begin
        a_r6_sizes_cover: assert (grp_lo(NG) == WIDTH)
            else $error("R6: group sizes do not sum to WIDTH");
    end

    always_comb begin
        if (!$isunknown({opa, opb, carry_in})) begin
            // R1: full-width arithmetic
            a_r1_total_arith: assert ({carry_out, sum} ==
                    ({1'b0, opa} + {1'b0, opb} + (WIDTH+1)'(carry_in)))
                else $error("R1: sum mismatch");
            // R3: all-propagate passes carry_in straight through
            if ((opa ^ opb) == {WIDTH{1'b1}}) begin
                a_r3_full_propagate: assert (carry_out == carry_in && sum == {WIDTH{~carry_in}})
                    else $error("R3: full propagate result wrong");
            end
        end
    end

endmodule

// File: tb/sim_csa_adder.sv
module sim_csa_adder;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [15:0] opa, opb;
    logic        cin;
    logic [15:0] s0, s1, s2;
    logic [5:0]  s3;
    logic        c0, c1, c2, c3;

    csa_adder u0 (.opa(opa), .opb(opb), .carry_in(cin), .sum(s0), .carry_out(c0));
    csa_adder #(.VAR_MODE(1), .SKIP2(1)) u_var (
        .opa(opa), .opb(opb), .carry_in(cin), .sum(s1), .carry_out(c1));
    csa_adder #(.SKIP2(1)) u_two (
        .opa(opa), .opb(opb), .carry_in(cin), .sum(s2), .carry_out(c2));
    csa_adder #(.WIDTH(6), .GRP(2), .SKIP2(1)) u_small (
        .opa(opa[5:0]), .opb(opb[5:0]), .carry_in(cin), .sum(s3), .carry_out(c3));

    typedef struct packed {
        logic [16:0] e16;
        logic [6:0]  e6;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    task automatic send(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tag);
        exp_t e;
        @(posedge clk);
        opa = a; opb = b; cin = ci;
        e.e16 = {1'b0, a} + {1'b0, b} + 17'(ci);
        e.e6  = {1'b0, a[5:0]} + {1'b0, b[5:0]} + 7'(ci);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic chk(input string tag, input string who, input logic [16:0] got, input logic [16:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%h exp=%h", tag, who, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "u0",      {c0, s0}, e.e16);
            chk(t, "u_var",   {c1, s1}, e.e16);
            chk(t, "u_two",   {c2, s2}, e.e16);
            chk(t, "u_small", {10'd0, c3, s3}, {10'd0, e.e6});
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; cin = 1'b0;
        send(16'h0000, 16'h0000, 1'b0, "R1 zero");
        send(16'hA5C3, ~16'hA5C3, 1'b0, "R3 all-propagate cin0");
        send(16'hA5C3, ~16'hA5C3, 1'b1, "R3 all-propagate cin1");
        send(16'h0000, 16'hFFFF, 1'b1, "R3 all-propagate ones");
        send(16'h0001, 16'hFFFF, 1'b0, "R2 gen bit0 ripple to top");
        send(16'h00F1, 16'h000F, 1'b0, "R4 group1 bypass");
        send(16'h0F0F, 16'h0000, 1'b1, "R4 groups 0 and 2 bypass");
        send(16'hF00F, 16'h0F00, 1'b1, "R5 group1 kill");
        send(16'h0000, 16'h0000, 1'b1, "R5 all kill cin1");
        send(16'hFFFF, 16'hFFFF, 1'b1, "R1 all generate");
        send(16'h00FF, 16'hFF00, 1'b1, "R7 pair bypass");
        send(16'h000F, 16'h0000, 1'b1, "R6 group boundary 3-4");
        for (int i = 0; i < 3000; i++)
            send(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        for (int i = 0; i < 500; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            send(r, ~r, 1'($urandom), "R3 random propagate");
        end
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int c = 0; c < 2; c++)
                    send({10'($urandom), 6'(a)}, {10'($urandom), 6'(b)}, 1'(c), "R7 exhaustive small");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule